// File: doc/BRIEF.md
# Typed Address Region Decoder

This block sorts every 24-bit byte address on a single-byte bus into one region of a fixed, ascending region table. Each region has an access type. From the address alone, and with no clock in the path, it reports whether the address hit a region, which table entry it hit, that entry's type, and the byte offset of the address inside the region. When a request is presented, the block registers it for one cycle. In that cycle it raises either a read strobe or a write strobe toward a numbered storage target, and it presents the registered offset and write byte.

Read data returns in the same cycle as the read strobe. The block takes it from a 32-bit big-endian word supplied by the addressed target, choosing the byte lane from the low offset bits. Reads that cannot be served get the filler byte 0xFF and raise no strobe. Writes that cannot be served are dropped and set a sticky error flag.

The table exercises several special mappings:
- One address carries a read-only register and a write-only register, each with its own target.
- Two colour windows share one target.
- A write-only mirror of a register sits 0x8000 above the original and accepts only 32-bit-qualified writes.

A five-state controller sequences each access. Its states are IDLE, READ, FILL, WRITE and DROP. On every clock edge the next state follows the request present at that edge:
- no request goes to IDLE;
- a read of a readable region goes to READ;
- any other read goes to FILL;
- a write to a writable region goes to WRITE;
- any other write goes to DROP.

Any state can move to any other on the next edge.

Top module: `memmap_decode`

Default table. Each entry lists index, start–end, type, read target / write target.
- 0: 0x000000–0x0FFFFF, RAM, 0/0
- 1: 0x800000–0x8FFFFF, ROM, 1/1
- 2: 0xF00004–0xF00007, read/write I/O, 2/2
- 3: 0xF00008–0xF0000B, read-only I/O, 3/3
- 4: 0xF00020–0xF00023, write-only I/O, 4/4
- 5: 0xF00400–0xF005FF, RAM, 5/5
- 6: 0xF00600–0xF007FF, RAM, 5/5
- 7: 0xF0211C–0xF0211F, read/write I/O, 6/7
- 8: 0xF0A11C–0xF0A11F, write-only I/O with wide-only writes, 7/7
- 9: 0xFFFFFF–0xFFFFFF, none (end marker)

## Requirements
- R1: `dec_type` reports the hit region's type code with no clock in the path: none=0, RAM=1, ROM=2, read-only I/O=4, write-only I/O=8, read/write I/O=12. Bit 2 means readable I/O and bit 3 means writable I/O. `dec_index` reports the table entry.
- R2: Lookup takes the lowest-numbered entry whose end is at or above the address. If that entry's start is above the address (a gap), the address is unmapped: `dec_hit`=0 and `dec_type`=0. A read of it returns 0xFF with no read strobe.
- R3: An address that reaches only the end marker, including 0xFFFFFF, is unmapped and reads return 0xFF.
- R4: `dec_offset` equals the address minus the region start. One cycle after a request, `acc_offset` carries that offset and `acc_target` carries the entry's target for the request direction.
- R5: Read data is big-endian. Offset bits [1:0]=0 select `tgt_word[31:24]`, and 3 selects `tgt_word[7:0]`.
- R6: A read of write-only I/O returns 0xFF with `bus_rvalid`=1 and `rd_stb`=0.
- R7: A write to ROM, read-only I/O or unmapped space raises no `wr_stb` and sets `wr_err`. Only reset clears `wr_err`.
- R8: At the split address (entry 7), reads strobe target 6 and writes strobe target 7.
- R9: Both colour windows (entries 5 and 6) map to target 5 at the same offset, so a byte written through one window is read back through the other.
- R10: The mirror entry 8 accepts a write only when `bus_wide`=1, strobing target 7. A write with `bus_wide`=0 is dropped as in R7.
- R11: `rd_stb` and `wr_stb` are never high together. Each strobe, and `bus_rvalid`, appears exactly one cycle after the corresponding request.
- R12: During and right after reset, `rd_stb`, `wr_stb`, `bus_rvalid` and `wr_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | Write is part of a 32-bit access |
| bus_addr | input | 24 | Byte address |
| bus_wdata | input | 8 | Write byte |
| dec_hit | output | 1 | Address lies in a typed region |
| dec_index | output | 4 | Selected table entry |
| dec_type | output | 4 | Region type code (0 when unmapped) |
| dec_offset | output | 24 | Address minus region start |
| rd_stb | output | 1 | Registered read strobe |
| wr_stb | output | 1 | Registered write strobe |
| acc_target | output | 3 | Storage target of the registered access |
| acc_offset | output | 24 | Offset of the registered access |
| acc_wdata | output | 8 | Write byte of the registered access |
| tgt_word | input | 32 | Big-endian word from the addressed target |
| bus_rvalid | output | 1 | Read data valid (served or filler) |
| bus_rdata | output | 8 | Read byte |
| wr_err | output | 1 | Sticky dropped-write flag |

## Verification
The bench builds the block with its defaults: `WORD_BYTES`=4 and the ten-entry table. With that table every type code, an address gap, the end marker, a shared colour target, a direction-split address and a wide-only mirror can all be reached from the bus. With four byte lanes, every lane position is read back against a byte-addressed stub model. Back-to-back requests alternate between directions, so write-then-read visibility through an aliased window and the stickiness of the error flag are both observed at the ports.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

    localparam int ADDR_W  = 24;
    localparam int NUM_REG = 10;
    localparam int IDX_W   = $clog2(NUM_REG);
    localparam int TGT_W   = 3;

    // Type codes; bit 2 = readable I/O, bit 3 = writable I/O
    typedef enum logic [3:0] {
        RT_NONE  = 4'd0,
        RT_RAM   = 4'd1,
        RT_ROM   = 4'd2,
        RT_IO_R  = 4'd4,
        RT_IO_W  = 4'd8,
        RT_IO_RW = 4'd12
    } rtype_e;

    typedef struct packed {
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
        rtype_e            kind;
        logic [TGT_W-1:0]  rd_tgt;
        logic [TGT_W-1:0]  wr_tgt;
        logic              wide_only;
    } region_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_FILL,
        ST_WRITE,
        ST_DROP
    } acc_state_e;

    // Ascending region table; last entry is the end marker
    function automatic region_t region_at(input int i);
        region_t r;
        r = '{lo: 24'hFFFFFF, hi: 24'hFFFFFF, kind: RT_NONE,
              rd_tgt: 3'd0, wr_tgt: 3'd0, wide_only: 1'b0};
        case (i)
            0: r = '{24'h000000, 24'h0FFFFF, RT_RAM,   3'd0, 3'd0, 1'b0};
            1: r = '{24'h800000, 24'h8FFFFF, RT_ROM,   3'd1, 3'd1, 1'b0};
            2: r = '{24'hF00004, 24'hF00007, RT_IO_RW, 3'd2, 3'd2, 1'b0};
            3: r = '{24'hF00008, 24'hF0000B, RT_IO_R,  3'd3, 3'd3, 1'b0};
            4: r = '{24'hF00020, 24'hF00023, RT_IO_W,  3'd4, 3'd4, 1'b0};
            5: r = '{24'hF00400, 24'hF005FF, RT_RAM,   3'd5, 3'd5, 1'b0};
            6: r = '{24'hF00600, 24'hF007FF, RT_RAM,   3'd5, 3'd5, 1'b0};
            7: r = '{24'hF0211C, 24'hF0211F, RT_IO_RW, 3'd6, 3'd7, 1'b0};
            8: r = '{24'hF0A11C, 24'hF0A11F, RT_IO_W,  3'd7, 3'd7, 1'b1};
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mm_region_match.sv
module mm_region_match
    import memmap_pkg::*;
#(
    parameter int N = NUM_REG
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx,
    output region_t           ent,
    output logic [ADDR_W-1:0] offset
);

    region_t    tab    [N];
    logic [N-1:0] end_ok;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_entry
            assign tab[g]    = region_at(g);
            assign end_ok[g] = (addr <= tab[g].hi);
        end
    endgenerate

    // Lowest entry whose end covers the address wins; end marker always covers
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (end_ok[i]) idx = i[IDX_W-1:0];
        end
        ent    = tab[idx];
        hit    = (addr >= ent.lo) && (ent.kind != RT_NONE);
        offset = hit ? (addr - ent.lo) : '0;
    end

endmodule

// File: rtl/mm_lane_pick.sv
module mm_lane_pick #(
    parameter int WORD_BYTES = 4,
    localparam int LANE_W    = $clog2(WORD_BYTES),
    localparam int WORD_W    = 8 * WORD_BYTES
) (
    input  logic [WORD_W-1:0] word,
    input  logic [LANE_W-1:0] lane,
    output logic [7:0]        byte_o
);

    logic [7:0] lanes [WORD_BYTES];

    genvar g;
    generate
        for (g = 0; g < WORD_BYTES; g++) begin : g_lane
            // Big-endian: lane 0 is the most significant byte
            assign lanes[g] = word[8*(WORD_BYTES-1-g) +: 8];
        end
    endgenerate

    assign byte_o = lanes[lane];

endmodule

// File: rtl/mm_access_ctl.sv
module mm_access_ctl
    import memmap_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_valid,
    input  logic   req_write,
    input  logic   req_wide,
    input  logic   hit,
    input  rtype_e kind,
    input  logic   wide_only,
    output logic   rd_stb,
    output logic   wr_stb,
    output logic   rvalid,
    output logic   err
);

    acc_state_e state, nxt;
    logic       can_read, can_write;

    assign can_read  = hit && ((kind == RT_RAM) || (kind == RT_ROM) || kind[2]);
    assign can_write = hit && ((kind == RT_RAM) || kind[3]) && (!wide_only || req_wide);

    always_comb begin
        nxt = ST_IDLE;
        if (req_valid) begin
            if (!req_write) nxt = can_read  ? ST_READ  : ST_FILL;
            else            nxt = can_write ? ST_WRITE : ST_DROP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            err   <= 1'b0;
        end else begin
            state <= nxt;
            if (nxt == ST_DROP) err <= 1'b1;
        end
    end

    always_comb begin
        rd_stb = 1'b0;
        wr_stb = 1'b0;
        rvalid = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_READ:  begin rd_stb = 1'b1; rvalid = 1'b1; end
            ST_FILL:  rvalid = 1'b1;
            ST_WRITE: wr_stb = 1'b1;
            ST_DROP:  ;
            default:  ;
        endcase
    end

endmodule

// File: rtl/memmap_decode.sv
module memmap_decode
    import memmap_pkg::*;
#(
    parameter int WORD_BYTES = 4,
    localparam int LANE_W    = $clog2(WORD_BYTES),
    localparam int WORD_W    = 8 * WORD_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic              bus_wide,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic              dec_hit,
    output logic [IDX_W-1:0]  dec_index,
    output logic [3:0]        dec_type,
    output logic [ADDR_W-1:0] dec_offset,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic [TGT_W-1:0]  acc_target,
    output logic [ADDR_W-1:0] acc_offset,
    output logic [7:0]        acc_wdata,
    input  logic [WORD_W-1:0] tgt_word,
    output logic              bus_rvalid,
    output logic [7:0]        bus_rdata,
    output logic              wr_err
);

    region_t    ent;
    logic [7:0] lane_byte;

    mm_region_match #(.N(NUM_REG)) u_match (
        .addr   (bus_addr),
        .hit    (dec_hit),
        .idx    (dec_index),
        .ent    (ent),
        .offset (dec_offset)
    );

    assign dec_type = dec_hit ? ent.kind : RT_NONE;

    mm_access_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (bus_valid),
        .req_write (bus_write),
        .req_wide  (bus_wide),
        .hit       (dec_hit),
        .kind      (ent.kind),
        .wide_only (ent.wide_only),
        .rd_stb    (rd_stb),
        .wr_stb    (wr_stb),
        .rvalid    (bus_rvalid),
        .err       (wr_err)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_target <= '0;
            acc_offset <= '0;
            acc_wdata  <= '0;
        end else if (bus_valid) begin
            acc_target <= bus_write ? ent.wr_tgt : ent.rd_tgt;
            acc_offset <= dec_offset;
            acc_wdata  <= bus_wdata;
        end
    end

    mm_lane_pick #(.WORD_BYTES(WORD_BYTES)) u_lane (
        .word   (tgt_word),
        .lane   (acc_offset[LANE_W-1:0]),
        .byte_o (lane_byte)
    );

    assign bus_rdata = rd_stb ? lane_byte : 8'hFF;

endmodule

// File: rtl/memmap_decode_chk.sv
module memmap_decode_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_valid,
    input logic       bus_write,
    input logic       dec_hit,
    input logic [3:0] dec_type,
    input logic       rd_stb,
    input logic       wr_stb,
    input logic       bus_rvalid,
    input logic [7:0] bus_rdata,
    input logic       wr_err
);

    // R11
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && wr_stb));

    // R11
    read_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> bus_rvalid);

    // R11
    write_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(bus_valid && bus_write));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> wr_err);

    // R6
    filler_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rvalid && !rd_stb) |-> (bus_rdata == 8'hFF));

    // R2
    unmapped_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_hit |-> (dec_type == 4'd0));

endmodule

bind memmap_decode memmap_decode_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .dec_hit    (dec_hit),
    .dec_type   (dec_type),
    .rd_stb     (rd_stb),
    .wr_stb     (wr_stb),
    .bus_rvalid (bus_rvalid),
    .bus_rdata  (bus_rdata),
    .wr_err     (wr_err)
);

// File: tb/memmap_decode_bench.sv
`timescale 1ns/1ps
module memmap_decode_bench;

    localparam int K_READ  = 0;
    localparam int K_FILL  = 1;
    localparam int K_WRITE = 2;
    localparam int K_DROP  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0, bus_wide = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        dec_hit;
    logic [3:0]  dec_index;
    logic [3:0]  dec_type;
    logic [23:0] dec_offset;
    logic        rd_stb, wr_stb, bus_rvalid, wr_err;
    logic [2:0]  acc_target;
    logic [23:0] acc_offset;
    logic [7:0]  acc_wdata, bus_rdata;
    logic [31:0] tgt_word;

    always #4 clk = ~clk;

    memmap_decode u_memmap_decode (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .dec_hit(dec_hit), .dec_index(dec_index), .dec_type(dec_type),
        .dec_offset(dec_offset), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .acc_target(acc_target), .acc_offset(acc_offset), .acc_wdata(acc_wdata),
        .tgt_word(tgt_word), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .wr_err(wr_err)
    );

    // Target stubs (written by the design) and reference copy (written by the driver)
    logic [7:0] stub_mem [8][256];
    logic [7:0] ref_mem  [8][256];

    always @(posedge clk) begin
        if (wr_stb) stub_mem[acc_target][acc_offset[7:0]] <= acc_wdata;
    end

    always_comb begin
        for (int k = 0; k < 4; k++)
            tgt_word[8*(3-k) +: 8] = stub_mem[acc_target][{acc_offset[7:2], 2'(k)}];
    end

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    typedef struct {
        int    kind;
        int    tgt;
        int    off;
        int    data;
        int    due;
        string req;
    } exp_t;

    exp_t sb_q[$];

    task automatic access(input bit wr, input logic [23:0] a, input logic [7:0] d,
                          input bit wide, input int kind, input int tgt, input int off,
                          input string req);
        exp_t it;
        @(negedge clk);
        bus_valid = 1'b1;
        bus_write = wr;
        bus_addr  = a;
        bus_wdata = d;
        bus_wide  = wide;
        it.kind = kind;
        it.tgt  = tgt;
        it.off  = off;
        it.req  = req;
        it.data = (kind == K_READ) ? int'(ref_mem[tgt][off[7:0]]) : 8'hFF;
        if (kind == K_WRITE) begin
            it.data = d;
            ref_mem[tgt][off[7:0]] = d;
        end
        it.due = cyc + 1;
        sb_q.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        bus_valid = 1'b0;
        bus_write = 1'b0;
        bus_wide  = 1'b0;
    endtask

    task automatic check_dec(input logic [23:0] a, input bit hit, input int typ,
                             input int idx, input int off, input string req);
        @(negedge clk);
        bus_valid = 1'b0;
        bus_addr  = a;
        #1;
        chk(dec_hit == hit, req, "dec_hit", dec_hit, hit);
        chk(dec_type == typ[3:0], req, "dec_type", dec_type, typ);
        if (hit) begin
            chk(dec_index == idx[3:0], req, "dec_index", dec_index, idx);
            chk(dec_offset == off[23:0], req, "dec_offset", dec_offset, off);
        end
    endtask

    // Monitor: pops the expected result due in this cycle
    always @(negedge clk) begin
        exp_t it;
        #1;
        if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
            it = sb_q.pop_front();
            case (it.kind)
                K_READ: begin
                    chk(rd_stb && !wr_stb && bus_rvalid, it.req, "read strobe",
                        {rd_stb, wr_stb, bus_rvalid}, 3'b101);
                    chk(acc_target == it.tgt[2:0], it.req, "read target", acc_target, it.tgt);
                    chk(acc_offset == it.off[23:0], it.req, "read offset", acc_offset, it.off);
                    chk(bus_rdata == it.data[7:0], it.req, "read data", bus_rdata, it.data);
                end
                K_FILL: begin
                    chk(!rd_stb && !wr_stb && bus_rvalid, it.req, "filler strobes",
                        {rd_stb, wr_stb, bus_rvalid}, 3'b001);
                    chk(bus_rdata == 8'hFF, it.req, "filler data", bus_rdata, 8'hFF);
                end
                K_WRITE: begin
                    chk(wr_stb && !rd_stb, it.req, "write strobe", {rd_stb, wr_stb}, 2'b01);
                    chk(acc_target == it.tgt[2:0], it.req, "write target", acc_target, it.tgt);
                    chk(acc_offset == it.off[23:0], it.req, "write offset", acc_offset, it.off);
                    chk(acc_wdata == it.data[7:0], it.req, "write data", acc_wdata, it.data);
                end
                default: begin
                    chk(!wr_stb && !rd_stb, it.req, "dropped strobes", {rd_stb, wr_stb}, 0);
                    chk(wr_err, it.req, "wr_err after drop", wr_err, 1);
                end
            endcase
        end
    end

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        for (int t = 0; t < 8; t++)
            for (int i = 0; i < 256; i++) begin
                stub_mem[t][i] = 8'((t * 37 + i * 3) & 8'hFF);
                ref_mem[t][i]  = 8'((t * 37 + i * 3) & 8'hFF);
            end

        // R12 reset state
        repeat (3) @(negedge clk);
        chk(!rd_stb && !wr_stb && !bus_rvalid && !wr_err, "R12", "outputs in reset",
            {rd_stb, wr_stb, bus_rvalid, wr_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rd_stb && !wr_stb && !bus_rvalid && !wr_err, "R12", "outputs after reset",
            {rd_stb, wr_stb, bus_rvalid, wr_err}, 0);

        // R1 type codes, R4 offsets, R2 gap, R3 end marker
        check_dec(24'h000010, 1, 1,  0, 24'h10, "R1");
        check_dec(24'h800005, 1, 2,  1, 5,      "R1");
        check_dec(24'hF00006, 1, 12, 2, 2,      "R1");
        check_dec(24'hF00009, 1, 4,  3, 1,      "R1");
        check_dec(24'hF00021, 1, 8,  4, 1,      "R1");
        check_dec(24'hF0060C, 1, 1,  6, 24'hC,  "R4");
        check_dec(24'h500000, 0, 0,  0, 0,      "R2");
        check_dec(24'hFFFFFF, 0, 0,  0, 0,      "R3");

        // R5 all four lanes, R4 offsets
        access(0, 24'h000010, 0, 0, K_READ, 0, 24'h10, "R5");
        access(0, 24'h000011, 0, 0, K_READ, 0, 24'h11, "R5");
        access(0, 24'h000012, 0, 0, K_READ, 0, 24'h12, "R5");
        access(0, 24'h000013, 0, 0, K_READ, 0, 24'h13, "R5");
        access(1, 24'h000012, 8'hA5, 0, K_WRITE, 0, 24'h12, "R4");
        access(0, 24'h000012, 0, 0, K_READ, 0, 24'h12, "R4");
        access(0, 24'h800007, 0, 0, K_READ, 1, 7, "R4");
        access(0, 24'hF00004, 0, 0, K_READ, 2, 0, "R1");
        access(1, 24'hF00005, 8'h11, 0, K_WRITE, 2, 1, "R1");
        access(0, 24'hF00008, 0, 0, K_READ, 3, 0, "R1");
        // R6 write-only read, R2 gap read, R3 end marker read
        access(0, 24'hF00020, 0, 0, K_FILL, 0, 0, "R6");
        access(0, 24'h500000, 0, 0, K_FILL, 0, 0, "R2");
        access(0, 24'hFFFFFF, 0, 0, K_FILL, 0, 0, "R3");
        // R8 direction split
        access(0, 24'hF0211D, 0, 0, K_READ, 6, 1, "R8");
        access(1, 24'hF0211E, 8'h3C, 0, K_WRITE, 7, 2, "R8");
        // R9 aliased colour windows
        access(1, 24'hF00410, 8'h5A, 0, K_WRITE, 5, 24'h10, "R9");
        access(0, 24'hF00610, 0, 0, K_READ, 5, 24'h10, "R9");
        access(1, 24'hF00614, 8'hC3, 0, K_WRITE, 5, 24'h14, "R9");
        access(0, 24'hF00414, 0, 0, K_READ, 5, 24'h14, "R9");
        // R10 wide mirror write, mirror read is filler
        access(1, 24'hF0A11C, 8'h77, 1, K_WRITE, 7, 0, "R10");
        access(0, 24'hF0A11C, 0, 0, K_FILL, 0, 0, "R10");
        idle();
        repeat (3) @(negedge clk);
        chk(!wr_err, "R7", "wr_err before any drop", wr_err, 0);

        // R10 narrow mirror write dropped, R7 drops
        access(1, 24'hF0A11D, 8'h01, 0, K_DROP, 0, 0, "R10");
        access(1, 24'h800007, 8'h02, 0, K_DROP, 0, 0, "R7");
        access(1, 24'hF00008, 8'h03, 0, K_DROP, 0, 0, "R7");
        access(1, 24'h500000, 8'h04, 0, K_DROP, 0, 0, "R7");
        // stored bytes unchanged by dropped writes
        access(0, 24'h800007, 0, 0, K_READ, 1, 7, "R7");
        access(0, 24'hF00008, 0, 0, K_READ, 3, 0, "R7");
        access(1, 24'h000020, 8'h99, 0, K_WRITE, 0, 24'h20, "R7");
        idle();
        repeat (3) @(negedge clk);
        chk(wr_err, "R7", "wr_err sticky after good write", wr_err, 1);
        chk(sb_q.size() == 0, "R11", "scoreboard drained", sb_q.size(), 0);

        // R12 reset clears the flag
        rst_n = 1'b0;
        @(negedge clk);
        chk(!wr_err && !rd_stb && !wr_stb, "R12", "reset clears", {wr_err, rd_stb, wr_stb}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        report();
    end

endmodule